// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan counters of a display pipe. It also drives active-low horizontal and vertical sync, an active-video flag and a single-cycle vertical-blank event. The scan geometry is not programmed as widths and porch lengths. It is programmed as edge positions along the line and along the frame, and the block derives the widths, blanking intervals and totals from those positions. It also exports the derived figures so that neighbouring logic, such as the pixel fetcher or the pixel-clock setup, can use them.

The horizontal counter advances once per character clock. A character clock is one pixel clock out of every `DIV` pixel clocks. Horizontal positions are counted in character clocks, and pixel figures are those positions scaled by the divisor. Vertical positions are in half-lines unless the interlace bit is set, in which case they are in whole lines. Software writes a shadow copy of the registers at any time. The whole copy becomes live together at the first cycle of the next frame, so a frame never mixes two geometries.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, hcount and vcount read 0, vbl_pulse and active read 0, and every register holds its default: HSE=2, HAS=4, HFP=12, HLE=14, VSE=2, VAS=4, VFP=12, VFE=16, DIV=1, MODE=0. The derived outputs therefore read act_width_px=8, htotal_px=14, act_height=4, vtotal=8 and frame_px=112.
- R2: The pixel-clock cycles are grouped into character clocks of `D` cycles each, where D is bits [3:0] of register 8 and a value of 0 counts as 1. hcount advances by one per character clock and wraps to 0 after reaching htotal_chars-1. vcount advances by one at each hcount wrap and wraps to 0 after vtotal-1.
- R3: The horizontal registers sit at these addresses: 0 is the sync end (HSE), 1 is the active start (HAS), 2 is the front-porch start (HFP) and 3 is the line end (HLE). The horizontal blank in character clocks is HAS+(HLE-HFP) and the active width is HFP-HAS. htotal_chars is their sum. act_width_px and htotal_px are these figures multiplied by D. hsync_n is 0 exactly while hcount < HSE.
- R4: The vertical registers sit at these addresses: 4 is the sync end (VSE), 5 is the active start (VAS), 6 is the front-porch start (VFP) and 7 is the frame end (VFE). Bit 0 of register 9 selects interlace. A function f(x) is x when interlace is set and x>>1 when it is clear. The outputs are then act_height=f(VFP-VAS) and vtotal=f(VAS+VFE-VFP)+act_height.
- R5: active is 1 exactly when HAS <= hcount < HFP and f(VAS) <= vcount < f(VAS)+act_height.
- R6: vsync_n is 0 exactly while vcount < f(VSE).
- R7: vbl_pulse is 1 for exactly one pixel clock. That clock is the first pixel clock of line f(VAS)+act_height, with hcount 0. It never coincides with active.
- R8: A register write changes nothing at the outputs during the current frame. All shadowed values take effect together at the first cycle of the next frame, where hcount and vcount are both 0.
- R9: frame_px equals htotal_px multiplied by vtotal, which is the number of pixel clocks in one frame.
- R10: A write to an address from 10 to 15 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (4) | Register address |
| cfg_wdata | input | DW (12) | Register write data |
| hcount | output | DW | Horizontal position in character clocks |
| vcount | output | DW | Vertical line position |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Active-video flag |
| vbl_pulse | output | 1 | One-cycle vertical-blank entry event |
| act_width_px | output | DW+DIVW | Active width in pixels |
| htotal_px | output | DW+DIVW | Line period in pixels |
| act_height | output | DW | Active height in lines |
| vtotal | output | DW | Frame period in lines |
| frame_px | output | 2*DW+DIVW | Pixel clocks per frame |

## Verification
Two events can fall in the same cycle. The first pair is the shadow-to-live load and the counter wrap to the frame origin. In that cycle the new limits, divisor and derived outputs must appear together with hcount=vcount=0, and the old frame's last cycle must still follow the old geometry. The second pair is the blank event and the falling edge of horizontal sync, which both occur at hcount 0. The bench provokes both by rewriting the whole register set, including the divisor, the interlace bit and ignored addresses, in the middle of a frame. It then compares every output on every pixel clock against a stream computed from the formulas, across three geometries.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Register slots; the order is the address decode
    typedef enum int {
        SLOT_HSYNC_END   = 0,
        SLOT_HACT_BEGIN  = 1,
        SLOT_HPORCH_BEGIN = 2,
        SLOT_HLINE_END   = 3,
        SLOT_VSYNC_END   = 4,
        SLOT_VACT_BEGIN  = 5,
        SLOT_VPORCH_BEGIN = 6,
        SLOT_VFRAME_END  = 7,
        SLOT_CHAR_DIV    = 8,
        SLOT_MODE        = 9
    } slot_e;

    localparam int NUM_REGS = 10;

    // Bit of the mode register that selects whole-line vertical counting
    localparam int MODE_INTERLACE_BIT = 0;

endpackage

// File: rtl/raster_regfile.sv
module raster_regfile
    import raster_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [DW-1:0]                 wdata_i,
    input  logic                          load_i,
    output logic [NUM_REGS-1:0][DW-1:0]   live_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DW-1:0] shadow;
        logic [NUM_REGS-1:0][DW-1:0] live;
    } rf_t;

    rf_t rf_d, rf_q, rf_rst;
    logic [NUM_REGS-1:0] hit;

    function automatic logic [DW-1:0] reset_val(input int idx);
        case (idx)
            SLOT_HSYNC_END:    return DW'(2);
            SLOT_HACT_BEGIN:   return DW'(4);
            SLOT_HPORCH_BEGIN: return DW'(12);
            SLOT_HLINE_END:    return DW'(14);
            SLOT_VSYNC_END:    return DW'(2);
            SLOT_VACT_BEGIN:   return DW'(4);
            SLOT_VPORCH_BEGIN: return DW'(12);
            SLOT_VFRAME_END:   return DW'(16);
            SLOT_CHAR_DIV:     return DW'(1);
            default:           return '0;
        endcase
    endfunction

    // Address decode, one comparator per slot; addresses past the map hit nothing
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_decode
        assign hit[gi] = we_i && (addr_i == AW'(gi));
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            rf_rst.shadow[i] = reset_val(i);
            rf_rst.live[i]   = reset_val(i);
        end
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) rf_d.shadow[i] = wdata_i;
        end
        if (load_i) rf_d.live = rf_d.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= rf_rst;
        else        rf_q <= rf_d;
    end

    assign live_o = rf_q.live;

    // R8: live geometry only moves at a frame boundary
    assert_live_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(rf_q.live));

endmodule

// File: rtl/raster_geometry.sv
module raster_geometry
    import raster_pkg::*;
#(
    parameter int DW   = 12,
    parameter int DIVW = 4
) (
    input  logic [NUM_REGS-1:0][DW-1:0] live_i,
    output logic [DIVW-1:0]             div_eff_o,
    output logic [DW-1:0]               hsync_end_o,
    output logic [DW-1:0]               hact_begin_o,
    output logic [DW-1:0]               hact_end_o,
    output logic [DW-1:0]               hchar_total_o,
    output logic [DW-1:0]               vsync_end_o,
    output logic [DW-1:0]               vact_begin_o,
    output logic [DW-1:0]               vact_end_o,
    output logic [DW-1:0]               vtotal_o,
    output logic [DW+DIVW-1:0]          act_width_px_o,
    output logic [DW+DIVW-1:0]          htotal_px_o,
    output logic [DW-1:0]               act_height_o,
    output logic [2*DW+DIVW-1:0]        frame_px_o
);

    localparam int PXW = DW + DIVW;
    localparam int FRW = 2 * DW + DIVW;

    logic            interlace;
    logic [DIVW-1:0] div_raw;
    logic [DW-1:0]   hwidth_c, hblank_c;
    logic [DW-1:0]   vheight, vblank;
    logic            unused_bits;

    function automatic logic [DW-1:0] to_lines(input logic [DW-1:0] x, input logic il);
        return il ? x : (x >> 1);
    endfunction

    always_comb begin
        interlace = live_i[SLOT_MODE][MODE_INTERLACE_BIT];
        div_raw   = live_i[SLOT_CHAR_DIV][DIVW-1:0];
        div_eff_o = (div_raw == '0) ? DIVW'(1) : div_raw;

        hsync_end_o  = live_i[SLOT_HSYNC_END];
        hact_begin_o = live_i[SLOT_HACT_BEGIN];
        hact_end_o   = live_i[SLOT_HPORCH_BEGIN];
        hwidth_c     = live_i[SLOT_HPORCH_BEGIN] - live_i[SLOT_HACT_BEGIN];
        hblank_c     = live_i[SLOT_HACT_BEGIN]
                     + (live_i[SLOT_HLINE_END] - live_i[SLOT_HPORCH_BEGIN]);
        hchar_total_o = hblank_c + hwidth_c;

        vheight = to_lines(live_i[SLOT_VPORCH_BEGIN] - live_i[SLOT_VACT_BEGIN], interlace);
        vblank  = to_lines(live_i[SLOT_VACT_BEGIN]
                         + (live_i[SLOT_VFRAME_END] - live_i[SLOT_VPORCH_BEGIN]), interlace);
        vtotal_o     = vblank + vheight;
        vact_begin_o = to_lines(live_i[SLOT_VACT_BEGIN], interlace);
        vact_end_o   = vact_begin_o + vheight;
        vsync_end_o  = to_lines(live_i[SLOT_VSYNC_END], interlace);
        act_height_o = vheight;

        act_width_px_o = PXW'(hwidth_c) * PXW'(div_eff_o);
        htotal_px_o    = PXW'(hchar_total_o) * PXW'(div_eff_o);
        frame_px_o     = FRW'(htotal_px_o) * FRW'(vtotal_o);
    end

    assign unused_bits = ^{live_i[SLOT_MODE][DW-1:1], live_i[SLOT_CHAR_DIV][DW-1:DIVW]};

endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
    parameter int DW   = 12,
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] div_eff_i,
    input  logic [DW-1:0]   hsync_end_i,
    input  logic [DW-1:0]   hact_begin_i,
    input  logic [DW-1:0]   hact_end_i,
    input  logic [DW-1:0]   htotal_i,
    input  logic [DW-1:0]   vsync_end_i,
    input  logic [DW-1:0]   vact_begin_i,
    input  logic [DW-1:0]   vact_end_i,
    input  logic [DW-1:0]   vtotal_i,
    output logic [DW-1:0]   hcount_o,
    output logic [DW-1:0]   vcount_o,
    output logic            hsync_n_o,
    output logic            vsync_n_o,
    output logic            active_o,
    output logic            vbl_o,
    output logic            frame_start_o
);

    typedef struct packed {
        logic [DIVW-1:0] phase;
        logic [DW-1:0]   h;
        logic [DW-1:0]   v;
        logic            vbl;
    } cnt_t;

    cnt_t st_d, st_q;

    logic [DW-1:0] hlim, vlim, vblank_line;
    logic          phase_last, h_last, v_last;

    always_comb begin
        hlim = (htotal_i == '0) ? '0 : htotal_i - DW'(1);
        vlim = (vtotal_i == '0) ? '0 : vtotal_i - DW'(1);
        // line at which blanking begins; with no bottom blank it is the frame origin
        vblank_line = (vact_end_i >= vtotal_i) ? '0 : vact_end_i;

        phase_last = (st_q.phase >= div_eff_i - DIVW'(1));
        h_last     = (st_q.h >= hlim);
        v_last     = (st_q.v >= vlim);
        frame_start_o = phase_last && h_last && v_last;

        st_d     = st_q;
        st_d.vbl = 1'b0;
        if (phase_last) begin
            st_d.phase = '0;
            if (h_last) begin
                st_d.h   = '0;
                st_d.v   = v_last ? '0 : st_q.v + DW'(1);
                st_d.vbl = (st_d.v == vblank_line);
            end else begin
                st_d.h = st_q.h + DW'(1);
            end
        end else begin
            st_d.phase = st_q.phase + DIVW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hcount_o  = st_q.h;
        vcount_o  = st_q.v;
        hsync_n_o = !(st_q.h < hsync_end_i);
        vsync_n_o = !(st_q.v < vsync_end_i);
        active_o  = (st_q.h >= hact_begin_i) && (st_q.h < hact_end_i)
                 && (st_q.v >= vact_begin_i) && (st_q.v < vact_end_i);
        vbl_o     = st_q.vbl;
    end

    // R2: counters hold between character-clock edges
    assert_char_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_last |=> ($stable(st_q.h) && $stable(st_q.v)));

    // R3: the last character of a line is followed by position 0
    assert_line_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_last && h_last) |=> (st_q.h == '0));

    // R7: the blank event lies outside the active window
    assert_vbl_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_o |-> !active_o);

    // R7: the blank event marks the first pixel of a line
    assert_vbl_line_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_o |-> (st_q.h == '0 && st_q.phase == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int DW   = 12,
    parameter int DIVW = 4,
    parameter int AW   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [DW-1:0]         cfg_wdata,
    output logic [DW-1:0]         hcount,
    output logic [DW-1:0]         vcount,
    output logic                  hsync_n,
    output logic                  vsync_n,
    output logic                  active,
    output logic                  vbl_pulse,
    output logic [DW+DIVW-1:0]    act_width_px,
    output logic [DW+DIVW-1:0]    htotal_px,
    output logic [DW-1:0]         act_height,
    output logic [DW-1:0]         vtotal,
    output logic [2*DW+DIVW-1:0]  frame_px
);

    logic [NUM_REGS-1:0][DW-1:0] live;
    logic                        frame_start;
    logic [DIVW-1:0]             div_eff;
    logic [DW-1:0]               hse, has, hae, hct, vse, vas, vae;

    raster_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .load_i  (frame_start),
        .live_o  (live)
    );

    raster_geometry #(.DW(DW), .DIVW(DIVW)) u_geom (
        .live_i         (live),
        .div_eff_o      (div_eff),
        .hsync_end_o    (hse),
        .hact_begin_o   (has),
        .hact_end_o     (hae),
        .hchar_total_o  (hct),
        .vsync_end_o    (vse),
        .vact_begin_o   (vas),
        .vact_end_o     (vae),
        .vtotal_o       (vtotal),
        .act_width_px_o (act_width_px),
        .htotal_px_o    (htotal_px),
        .act_height_o   (act_height),
        .frame_px_o     (frame_px)
    );

    raster_counters #(.DW(DW), .DIVW(DIVW)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_eff_i     (div_eff),
        .hsync_end_i   (hse),
        .hact_begin_i  (has),
        .hact_end_i    (hae),
        .htotal_i      (hct),
        .vsync_end_i   (vse),
        .vact_begin_i  (vas),
        .vact_end_i    (vae),
        .vtotal_i      (vtotal),
        .hcount_o      (hcount),
        .vcount_o      (vcount),
        .hsync_n_o     (hsync_n),
        .vsync_n_o     (vsync_n),
        .active_o      (active),
        .vbl_o         (vbl_pulse),
        .frame_start_o (frame_start)
    );

    // R8: a new frame opens at the scan origin
    assert_frame_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (hcount == '0 && vcount == '0));

endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] hcount, vcount, act_height, vtotal;
    logic        hsync_n, vsync_n, active, vbl_pulse;
    logic [15:0] act_width_px, htotal_px;
    logic [27:0] frame_px;

    raster_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hcount(hcount), .vcount(vcount),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active),
        .vbl_pulse(vbl_pulse), .act_width_px(act_width_px),
        .htotal_px(htotal_px), .act_height(act_height), .vtotal(vtotal),
        .frame_px(frame_px)
    );

    always #10 clk = ~clk;

    typedef int cfg_t [10];
    typedef struct {
        int h, v, hs, vs, act, vbl, wpx, htpx, ht, vt, fpx;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected stream for one frame, computed from the requirement formulas
    task automatic push_frame(input cfg_t c, input bit skip_first);
        int d, il, hbl, hw, htc, vh, vb, vt, vst, ven, vse, vbl_line;
        d   = ((c[8] & 15) == 0) ? 1 : (c[8] & 15);
        il  = c[9] & 1;
        hw  = c[2] - c[1];
        hbl = c[1] + (c[3] - c[2]);
        htc = hbl + hw;
        vh  = il ? (c[6] - c[5]) : ((c[6] - c[5]) >> 1);
        vb  = il ? (c[5] + c[7] - c[6]) : ((c[5] + c[7] - c[6]) >> 1);
        vt  = vb + vh;
        vst = il ? c[5] : (c[5] >> 1);
        ven = vst + vh;
        vse = il ? c[4] : (c[4] >> 1);
        vbl_line = (ven >= vt) ? 0 : ven;
        for (int v = 0; v < vt; v++)
            for (int h = 0; h < htc; h++)
                for (int p = 0; p < d; p++) begin
                    exp_t e;
                    if (skip_first && v == 0 && h == 0 && p == 0) continue;
                    e.h = h; e.v = v;
                    e.hs  = (h < c[0]) ? 0 : 1;
                    e.vs  = (v < vse) ? 0 : 1;
                    e.act = (h >= c[1] && h < c[2] && v >= vst && v < ven) ? 1 : 0;
                    e.vbl = (h == 0 && p == 0 && v == vbl_line) ? 1 : 0;
                    e.wpx = hw * d; e.htpx = htc * d;
                    e.ht = vh; e.vt = vt; e.fpx = htc * d * vt;
                    q.push_back(e);
                end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 12'(d);
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Monitor: pop one expected item per pixel clock and compare
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cyc++;
                chk(int'(hcount) == e.h, "R2 hcount", int'(hcount), e.h);
                chk(int'(vcount) == e.v, "R2 vcount", int'(vcount), e.v);
                chk(int'(hsync_n) == e.hs, "R3 hsync_n", int'(hsync_n), e.hs);
                chk(int'(vsync_n) == e.vs, "R6 vsync_n", int'(vsync_n), e.vs);
                chk(int'(active) == e.act, "R5 active", int'(active), e.act);
                chk(int'(vbl_pulse) == e.vbl, "R7 vbl_pulse", int'(vbl_pulse), e.vbl);
                chk(int'(act_width_px) == e.wpx, "R3/R8 act_width_px", int'(act_width_px), e.wpx);
                chk(int'(htotal_px) == e.htpx, "R3/R8 htotal_px", int'(htotal_px), e.htpx);
                chk(int'(act_height) == e.ht, "R4/R8 act_height", int'(act_height), e.ht);
                chk(int'(vtotal) == e.vt, "R4/R8 vtotal", int'(vtotal), e.vt);
                chk(int'(frame_px) == e.fpx, "R9 frame_px", int'(frame_px), e.fpx);
            end
        end
    end

    // Driver
    initial begin
        cfg_t cfg_a, cfg_b, cfg_c;
        cfg_a = '{2, 4, 12, 14, 2, 4, 12, 16, 1, 0};
        cfg_b = '{1, 2, 7, 9, 1, 1, 4, 5, 2, 1};        // divide by 2, interlace
        cfg_c = '{3, 3, 13, 16, 4, 3, 9, 11, 16, 0};    // divisor field 0 -> 1, half-lines

        // R8: writes in one frame show up only in the next
        push_frame(cfg_a, 1'b1);
        push_frame(cfg_b, 1'b0);
        push_frame(cfg_c, 1'b0);
        push_frame(cfg_c, 1'b0);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(hcount == 0, "R1 hcount", int'(hcount), 0);
        chk(vcount == 0, "R1 vcount", int'(vcount), 0);
        chk(active == 0, "R1 active", int'(active), 0);
        chk(vbl_pulse == 0, "R1 vbl_pulse", int'(vbl_pulse), 0);
        chk(act_width_px == 8, "R1 act_width_px", int'(act_width_px), 8);
        chk(htotal_px == 14, "R1 htotal_px", int'(htotal_px), 14);
        chk(act_height == 4, "R1 act_height", int'(act_height), 4);
        chk(vtotal == 8, "R1 vtotal", int'(vtotal), 8);
        chk(frame_px == 112, "R1 frame_px", int'(frame_px), 112);

        @(negedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;

        // Frame 1: load the second geometry into the shadow, plus R10 stray writes
        for (int i = 0; i < 10; i++) wr(i, cfg_b[i]);
        wr(10, 12'hfff);
        wr(15, 12'h000);

        while (cyc < 115) @(negedge clk);
        // Frame 2: third geometry, plus another R10 stray write
        for (int i = 0; i < 10; i++) wr(i, cfg_c[i]);
        wr(12, 12'h7ff);

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule